// File: doc/BRIEF.md
# Day and Time-of-Day Real-Time Clock

This block is a calendar-free real-time clock core. A free-running tick enable is divided by a sub-second prescaler into one-second steps. Each step advances a seconds-of-day counter. When that counter wraps past the last second of the day, a separate day counter advances. Software sees the seconds-of-day value as two registers, an 8-bit low part and a 9-bit high part, plus a 15-bit day register. A second set of registers with the same widths holds an alarm instant.

Two interrupt sources are kept in a sticky status register. One is set when the running instant reaches the alarm instant. The other is set on every one-second step. An enable register masks each source, and the single interrupt output is high while any enabled status bit is set. Software sets the time by writing the high and day parts first and the low part last. The low-part write commits the time and restarts the second phase, so counting resumes exactly from the written value. Writing zero to the low part first gives software 255 seconds in which the high part cannot change.

The register port is a plain single-cycle interface with no back-pressure. A write takes effect at the clock edge where `wr_en` is high. `rdata` is a combinational view of the addressed register's live value. Reads are not shadow-latched, so software that reads the low and high parts separately can see a torn value across a carry.

Top module: `rtc_daytime_core`

## Requirements
- R1: After reset, time of day and day are 0, both status bits and both enable bits are 0, `irq` is 0, and the alarm registers read all ones (low 0xFF, high 0x1FF, day 0x7FFF).
- R2: The time advances by one second only after TICKS_PER_SEC cycles in which `tick_en` is high. Cycles with `tick_en` low do not advance the prescaler.
- R3: Each one-second step adds 1 to the 17-bit seconds-of-day value. Register address 0 reads bits 7:0 and address 1 reads bits 16:8, so a carry out of the low part increments the high part.
- R4: A step taken from 86399, or from any written value above it, sets the time of day to 0 and adds 1 to the day (address 2).
- R5: The day counter is 15 bits wide and wraps from 32767 to 0.
- R6: Writes keep only the field width. The low part (address 0) keeps 8 bits, the high part (address 1) keeps 9 bits and the day (address 2) keeps 15 bits. The alarm registers at addresses 3 (low), 4 (high) and 5 (day) have the same widths.
- R7: A write to the low part clears the prescaler. The next step comes a full TICKS_PER_SEC ticks after that write, and counting continues from exactly the written value.
- R8: After zero is written to the low part, the high part holds its value for the next 255 seconds and changes on the 256th.
- R9: When day and time of day become equal to the alarm registers, status bit 0 (address 6) is set.
- R10: Every one-second step sets status bit 1. Writing 1 to a status bit clears it. Writing 0 leaves it unchanged.
- R11: `irq` is high exactly when some status bit is set and its enable bit at address 7 is set. Bit 0 is the alarm and bit 1 is the second.
- R12: The alarm status is set only when the match begins. Clearing it while the time still equals the alarm leaves it clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Sub-second tick enable for the prescaler |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address (0..7) |
| wdata | input | 15 | Write data |
| rdata | output | 15 | Live value of the addressed register |
| irq | output | 1 | OR of enabled sticky status bits |

## Verification
The carry path is swept with every one of the 256 low-part values, each paired with a different high part and day. This separates a correct low-to-high carry from a stuck or misplaced carry. A 256-second run after a zero low-part write separates the 255-second safe window from an off-by-one carry point. Writes at 86398, 86399, an out-of-range value and day 32767 separate the day rollover from the 15-bit day wrap. A low-part write in the middle of a second tells a prescaler that restarts apart from one that keeps its phase. The alarm is approached from below, masked and unmasked, and cleared while still matching. These patterns separate level-triggered from edge-triggered alarm status and show the enable gating of each source.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int ADDR_W = 3;
  localparam int LO_W   = 8;

  typedef enum logic [ADDR_W-1:0] {
    RA_TOD_LO  = 3'd0,
    RA_TOD_HI  = 3'd1,
    RA_DAY     = 3'd2,
    RA_ALM_LO  = 3'd3,
    RA_ALM_HI  = 3'd4,
    RA_ALM_DAY = 3'd5,
    RA_STAT    = 3'd6,
    RA_EN      = 3'd7
  } rtc_reg_e;

  localparam int IRQ_ALM = 0;
  localparam int IRQ_SEC = 1;
  localparam int IRQ_N   = 2;
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int TICKS_PER_SEC = 32768
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_en,
  input  logic clear,
  output logic sec_step,
  output logic [$clog2(TICKS_PER_SEC)-1:0] cnt
);
  localparam int PRE_W = $clog2(TICKS_PER_SEC);
  localparam logic [PRE_W-1:0] LAST = PRE_W'(TICKS_PER_SEC - 1);

  assign sec_step = tick_en && !clear && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)       cnt <= '0;
    else if (clear)   cnt <= '0;
    else if (tick_en) cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
  end
endmodule

// File: rtl/rtc_timebase.sv
module rtc_timebase #(
  parameter int SECS_PER_DAY = 86400,
  parameter int DAY_W        = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sec_step,
  input  logic wr_lo,
  input  logic wr_hi,
  input  logic wr_day,
  input  logic [rtc_pkg::LO_W-1:0] wdata_lo,
  input  logic [$clog2(SECS_PER_DAY)-rtc_pkg::LO_W-1:0] wdata_hi,
  input  logic [DAY_W-1:0] wdata_day,
  output logic [$clog2(SECS_PER_DAY)-1:0] tod,
  output logic [DAY_W-1:0] day
);
  localparam int TOD_W = $clog2(SECS_PER_DAY);
  localparam int LO_W  = rtc_pkg::LO_W;
  localparam logic [TOD_W-1:0] LAST_SEC = TOD_W'(SECS_PER_DAY - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tod <= '0;
      day <= '0;
    end else if (wr_lo) begin
      tod[LO_W-1:0] <= wdata_lo;
    end else if (wr_hi) begin
      tod[TOD_W-1:LO_W] <= wdata_hi;
    end else if (wr_day) begin
      day <= wdata_day;
    end else if (sec_step) begin
      if (tod >= LAST_SEC) begin
        tod <= '0;
        day <= day + 1'b1;
      end else begin
        tod <= tod + 1'b1;
      end
    end
  end
endmodule

// File: rtl/rtc_alarm.sv
module rtc_alarm #(
  parameter int SECS_PER_DAY = 86400,
  parameter int DAY_W        = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_lo,
  input  logic wr_hi,
  input  logic wr_day,
  input  logic [rtc_pkg::LO_W-1:0] wdata_lo,
  input  logic [$clog2(SECS_PER_DAY)-rtc_pkg::LO_W-1:0] wdata_hi,
  input  logic [DAY_W-1:0] wdata_day,
  input  logic [$clog2(SECS_PER_DAY)-1:0] tod,
  input  logic [DAY_W-1:0] day,
  output logic [$clog2(SECS_PER_DAY)-1:0] alm_tod,
  output logic [DAY_W-1:0] alm_day,
  output logic hit
);
  localparam int LO_W = rtc_pkg::LO_W;
  localparam int TOD_W = $clog2(SECS_PER_DAY);

  logic match, match_q;

  assign match = (tod == alm_tod) && (day == alm_day);
  assign hit   = match && !match_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      alm_tod <= '1;
      alm_day <= '1;
      match_q <= 1'b0;
    end else begin
      match_q <= match;
      if (wr_lo)  alm_tod[LO_W-1:0]     <= wdata_lo;
      if (wr_hi)  alm_tod[TOD_W-1:LO_W] <= wdata_hi;
      if (wr_day) alm_day               <= wdata_day;
    end
  end
endmodule

// File: rtl/rtc_irq.sv
module rtc_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic [rtc_pkg::IRQ_N-1:0] set,
  input  logic wr_stat,
  input  logic wr_en,
  input  logic [rtc_pkg::IRQ_N-1:0] wdata,
  output logic [rtc_pkg::IRQ_N-1:0] stat,
  output logic [rtc_pkg::IRQ_N-1:0] en,
  output logic irq
);
  localparam int N = rtc_pkg::IRQ_N;

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_src
      always_ff @(posedge clk) begin
        if (!rst_n)                    stat[g] <= 1'b0;
        else if (set[g])               stat[g] <= 1'b1;
        else if (wr_stat && wdata[g])  stat[g] <= 1'b0;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n)     en <= '0;
    else if (wr_en) en <= wdata;
  end

  assign irq = |(stat & en);
endmodule

// File: rtl/rtc_daytime_core.sv
module rtc_daytime_core #(
  parameter int SECS_PER_DAY  = 86400,
  parameter int DAY_W         = 15,
  parameter int TICKS_PER_SEC = 32768
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_en,
  input  logic        wr_en,
  input  logic [2:0]  addr,
  input  logic [14:0] wdata,
  output logic [14:0] rdata,
  output logic        irq
);
  import rtc_pkg::*;

  localparam int TOD_W = $clog2(SECS_PER_DAY);
  localparam int HI_W  = TOD_W - LO_W;
  localparam int PRE_W = $clog2(TICKS_PER_SEC);
  localparam int DW    = 15;

  rtc_reg_e ra;
  assign ra = rtc_reg_e'(addr);

  logic wr_tlo, wr_thi, wr_tday, wr_alo, wr_ahi, wr_aday, wr_stat, wr_ien;
  assign wr_tlo  = wr_en && (ra == RA_TOD_LO);
  assign wr_thi  = wr_en && (ra == RA_TOD_HI);
  assign wr_tday = wr_en && (ra == RA_DAY);
  assign wr_alo  = wr_en && (ra == RA_ALM_LO);
  assign wr_ahi  = wr_en && (ra == RA_ALM_HI);
  assign wr_aday = wr_en && (ra == RA_ALM_DAY);
  assign wr_stat = wr_en && (ra == RA_STAT);
  assign wr_ien  = wr_en && (ra == RA_EN);

  logic             sec_step;
  logic [PRE_W-1:0] pre_cnt;
  logic [TOD_W-1:0] tod_q, alm_tod;
  logic [DAY_W-1:0] day_q, alm_day;
  logic             alm_hit;
  logic [IRQ_N-1:0] stat_q, en_q, irq_set;

  rtc_prescaler #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_pre (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .clear(wr_tlo),
    .sec_step(sec_step), .cnt(pre_cnt)
  );

  rtc_timebase #(.SECS_PER_DAY(SECS_PER_DAY), .DAY_W(DAY_W)) u_tb (
    .clk(clk), .rst_n(rst_n), .sec_step(sec_step),
    .wr_lo(wr_tlo), .wr_hi(wr_thi), .wr_day(wr_tday),
    .wdata_lo(wdata[LO_W-1:0]), .wdata_hi(wdata[HI_W-1:0]),
    .wdata_day(wdata[DAY_W-1:0]), .tod(tod_q), .day(day_q)
  );

  rtc_alarm #(.SECS_PER_DAY(SECS_PER_DAY), .DAY_W(DAY_W)) u_alm (
    .clk(clk), .rst_n(rst_n),
    .wr_lo(wr_alo), .wr_hi(wr_ahi), .wr_day(wr_aday),
    .wdata_lo(wdata[LO_W-1:0]), .wdata_hi(wdata[HI_W-1:0]),
    .wdata_day(wdata[DAY_W-1:0]), .tod(tod_q), .day(day_q),
    .alm_tod(alm_tod), .alm_day(alm_day), .hit(alm_hit)
  );

  always_comb begin
    irq_set          = '0;
    irq_set[IRQ_ALM] = alm_hit;
    irq_set[IRQ_SEC] = sec_step;
  end

  rtc_irq u_irq (
    .clk(clk), .rst_n(rst_n), .set(irq_set),
    .wr_stat(wr_stat), .wr_en(wr_ien), .wdata(wdata[IRQ_N-1:0]),
    .stat(stat_q), .en(en_q), .irq(irq)
  );

  always_comb begin
    case (ra)
      RA_TOD_LO:  rdata = DW'(tod_q[LO_W-1:0]);
      RA_TOD_HI:  rdata = DW'(tod_q[TOD_W-1:LO_W]);
      RA_DAY:     rdata = DW'(day_q);
      RA_ALM_LO:  rdata = DW'(alm_tod[LO_W-1:0]);
      RA_ALM_HI:  rdata = DW'(alm_tod[TOD_W-1:LO_W]);
      RA_ALM_DAY: rdata = DW'(alm_day);
      RA_STAT:    rdata = DW'(stat_q);
      default:    rdata = DW'(en_q);
    endcase
  end
endmodule

// File: rtl/rtc_daytime_chk.sv
module rtc_daytime_chk #(
  parameter int SECS_PER_DAY  = 86400,
  parameter int DAY_W         = 15,
  parameter int TICKS_PER_SEC = 32768
) (
  input logic clk,
  input logic rst_n,
  input logic wr_en,
  input logic [2:0] addr,
  input logic sec_step,
  input logic [$clog2(TICKS_PER_SEC)-1:0] pre_cnt,
  input logic [$clog2(SECS_PER_DAY)-1:0] tod,
  input logic [DAY_W-1:0] day,
  input logic [1:0] stat,
  input logic [1:0] en,
  input logic irq
);
  localparam int TOD_W = $clog2(SECS_PER_DAY);
  localparam logic [TOD_W-1:0] LAST_SEC = TOD_W'(SECS_PER_DAY - 1);

  logic time_wr;
  assign time_wr = wr_en && (addr <= 3'd2);

  AST_STEP_INC: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_step && !time_wr && tod < LAST_SEC) |=> (tod == $past(tod) + 1'b1 && day == $past(day))); // R3
  AST_DAY_ROLL: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_step && !time_wr && tod == LAST_SEC) |=> (tod == '0 && day == DAY_W'($past(day) + 1'b1))); // R4
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!sec_step && !time_wr) |=> ($stable(tod) && $stable(day))); // R2
  AST_LO_CLEARS_PRE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'd0) |=> (pre_cnt == '0)); // R7
  AST_SEC_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    sec_step |=> stat[1]); // R10
  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (en == 2'b00) |-> !irq); // R11
endmodule

bind rtc_daytime_core rtc_daytime_chk #(
  .SECS_PER_DAY(SECS_PER_DAY), .DAY_W(DAY_W), .TICKS_PER_SEC(TICKS_PER_SEC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
  .sec_step(sec_step), .pre_cnt(pre_cnt), .tod(tod_q), .day(day_q),
  .stat(stat_q), .en(en_q), .irq(irq)
);

// File: tb/rtc_daytime_core_tb.sv
module rtc_daytime_core_tb;
  localparam int TPS = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  addr = 3'd0;
  logic [14:0] wdata = '0;
  logic [14:0] rdata;
  logic        irq;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  rtc_daytime_core #(.SECS_PER_DAY(86400), .DAY_W(15), .TICKS_PER_SEC(TPS)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  always #10 clk = ~clk;

  task automatic check(input string tag, input int got, input int exp);
    n_run++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; addr = 3'(a); wdata = 15'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output int v);
    @(negedge clk);
    addr = 3'(a);
    #1 v = int'(rdata);
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tick_en = 1'b1;
    end
    @(negedge clk);
    tick_en = 1'b0;
  endtask

  task automatic set_time(input int d, input int t);
    wr(1, t >> 8);
    wr(2, d);
    wr(0, t & 255);
  endtask

  task automatic expect_time(input string tag, input int d, input int t);
    int v;
    rd(0, v); check(tag, v, t & 255);
    rd(1, v); check(tag, v, t >> 8);
    rd(2, v); check(tag, v, d);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got 0 expected 1 (run completion)");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    expect_time("R1 time", 0, 0);
    rd(3, v); check("R1 alarm lo", v, 8'hFF);
    rd(4, v); check("R1 alarm hi", v, 9'h1FF);
    rd(5, v); check("R1 alarm day", v, 15'h7FFF);
    rd(6, v); check("R1 stat", v, 0);
    rd(7, v); check("R1 en", v, 0);
    check("R1 irq", int'(irq), 0);

    // R2 prescaler needs TPS enabled ticks
    set_time(4, 5000);
    tick(TPS - 1);
    expect_time("R2 before full second", 4, 5000);
    tick(1);
    expect_time("R2 after full second", 4, 5001);

    // R3 sweep every low value across the carry
    for (int lo = 0; lo < 256; lo++) begin
      int t = ((lo * 7) % 300) * 256 + lo;
      set_time(lo * 3, t);
      tick(TPS);
      expect_time("R3 carry sweep", lo * 3, t + 1);
    end

    // R4 day rollover
    set_time(10, 86398);
    tick(TPS);
    expect_time("R4 last second", 10, 86399);
    tick(TPS);
    expect_time("R4 rollover", 11, 0);

    // R5 day wrap
    set_time(32767, 86399);
    tick(TPS);
    expect_time("R5 day wrap", 0, 0);

    // R6 field widths and out-of-range wrap (R4)
    wr(1, 16'h7FFF); rd(1, v); check("R6 hi width", v, 9'h1FF);
    wr(2, 16'h7FFF); rd(2, v); check("R6 day width", v, 15'h7FFF);
    wr(0, 16'h7FFF); rd(0, v); check("R6 lo width", v, 8'hFF);
    wr(4, 16'h7FFF); rd(4, v); check("R6 alarm hi width", v, 9'h1FF);
    wr(3, 16'h7F12); rd(3, v); check("R6 alarm lo width", v, 8'h12);
    tick(TPS);
    expect_time("R4 out-of-range wrap", 0, 0);

    // R7 low write restarts the second phase
    set_time(2, 700);
    tick(2);
    wr(0, 8'h10);
    tick(TPS - 1);
    expect_time("R7 no early step", 2, 512 + 16);
    tick(1);
    expect_time("R7 full second", 2, 512 + 17);

    // R8 zero-low safe window
    set_time(7, 16'h1280);
    wr(0, 0);
    for (int k = 1; k < 256; k++) begin
      tick(TPS);
      rd(1, v); check("R8 hi held", v, 8'h12);
      rd(0, v); check("R8 lo counts", v, k);
    end
    tick(TPS);
    rd(1, v); check("R8 hi steps", v, 8'h13);
    rd(0, v); check("R8 lo wraps", v, 0);

    // R9 alarm, R11 masking, R12 edge, R10 sec status
    wr(7, 0);
    wr(5, 3); wr(4, 3); wr(3, 8'hE8);       // alarm at day 3, tod 1000
    set_time(3, 997);
    wr(6, 3);
    rd(6, v); check("R10 w1c both", v, 0);
    tick(2 * TPS);
    rd(6, v); check("R9 not yet", v & 1, 0);
    check("R10 sec stat", (v >> 1) & 1, 1);
    tick(TPS);
    rd(6, v); check("R9 alarm hit", v & 1, 1);
    check("R11 masked", int'(irq), 0);
    wr(7, 1);
    #1 check("R11 alarm enabled", int'(irq), 1);
    wr(6, 1);
    rd(6, v); check("R12 cleared stays clear", v, 2);
    check("R11 alarm cleared", int'(irq), 0);
    wr(7, 2);
    #1 check("R11 sec enabled", int'(irq), 1);
    wr(6, 2);
    rd(6, v); check("R10 sec cleared", v, 0);
    check("R11 none pending", int'(irq), 0);
    tick(TPS);
    rd(6, v); check("R10 next second", v, 2);
    check("R11 sec pending", int'(irq), 1);
    check("R12 no rehit past alarm", v & 1, 0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule